// File: doc/BRIEF.md
# Round-Robin Event Builder Selector

This block decides which of sixteen downstream event builders receives each accepted trigger event. Every event arrives as a one-cycle strobe with a 4-bit trigger type. A 32-bit configuration word sets four things: which builders may take events, how many consecutive events go to one builder, and whether calibration triggers go to a fixed builder instead.

Ordinary events rotate through the enabled builders in ascending order. A group count keeps the selection on one builder for several events in a row, so that the builder can pack them into one large packet. When calibration routing is on, events of trigger type 0xE go to a dedicated builder and do not disturb the rotation. The result leaves the block one clock after the strobe, as an index and as a one-hot vector, with a one-cycle valid pulse.

Top module: `evb_rr_select`

## Requirements
- R1: The result for a strobe taken at a clock edge appears after that edge. `sel_valid` is high for exactly the cycle after each strobe cycle. While `sel_valid` is high, `sel_onehot` has only bit `sel_idx` set. While it is low, `sel_onehot` is zero.
- R2: An ordinary event goes only to a builder whose enable bit is set. The enable bits are `cfg_word[15:0]`, and bit i enables builder i.
- R3: When the selection advances, it moves to the next higher enabled builder and wraps past 15 to the lowest enabled one. Disabled builders are skipped without any extra cycle.
- R4: The group count is `cfg_word[23:16]`. That many consecutive ordinary events go to the same builder before the selection advances.
- R5: A group count of 0 behaves like a count of 1.
- R6: When `cfg_word[28]` is 1, an event of trigger type 0xE goes to builder `cfg_word[27:24]`. This holds whatever the enable bits are.
- R7: When `cfg_word[28]` is 0, an event of trigger type 0xE is treated as an ordinary event.
- R8: A calibration event routed under R6 does not move the rotation pointer and does not advance the group counter.
- R9: When all enable bits are zero, every ordinary event goes to builder 0 and the rotation state is left unchanged.
- R10: If the builder the pointer rests on has been disabled, the next ordinary event goes to the next enabled builder above it. That event starts a fresh group.
- R11: Reset clears the outputs, puts the pointer on builder 0 and clears the group counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_stb | input | 1 | One-cycle strobe per accepted event |
| evt_type | input | 4 | Trigger type of the event |
| cfg_word | input | 32 | Enable bits, group count, calibration builder and calibration enable |
| sel_valid | output | 1 | Result pulse, one cycle after the strobe |
| sel_idx | output | 4 | Chosen builder index |
| sel_onehot | output | 16 | Chosen builder as a one-hot vector |

## Verification
The block has two pieces of hidden state, the pointer and the group counter. Either one being wrong shows up at `sel_idx` on the next ordinary event, or at the latest on the event that closes the current group. A calibration event that wrongly disturbs that state changes the builder chosen for the very next ordinary event. The bench therefore places calibration events in the middle of groups and follows each one with an ordinary event. It also changes the enable bits while a group is in progress, and checks each result in the cycle right after its strobe.

// File: rtl/evb_rr_select.sv
module evb_rr_select #(
  parameter logic [3:0] CAL_TYPE = 4'hE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_stb,
  input  logic [3:0]  evt_type,
  input  logic [31:0] cfg_word,
  output logic        sel_valid,
  output logic [3:0]  sel_idx,
  output logic [15:0] sel_onehot
);
  localparam int NB = 16;
  localparam int IW = $clog2(NB);
  localparam int GW = 8;

  logic [NB-1:0] mask;
  logic [GW-1:0] grp;
  logic [IW-1:0] cal_idx;
  logic          cal_en;
  assign mask    = cfg_word[15:0];
  assign grp     = cfg_word[23:16];
  assign cal_idx = cfg_word[27:24];
  assign cal_en  = cfg_word[28];

  logic [IW-1:0] ptr;
  logic [GW-1:0] cnt;

  function automatic logic [IW-1:0] next_en(input logic [IW-1:0] p, input logic [NB-1:0] m);
    logic [IW-1:0] r;
    r = p;
    for (int k = NB - 1; k >= 1; k--)
      if (m[IW'(32'(p) + k)]) r = IW'(32'(p) + k);
    return r;
  endfunction

  logic          is_cal, any_en, cur_ok, grp_done;
  logic [IW-1:0] cur, pick;
  logic [GW-1:0] cnt_inc, limit;

  assign is_cal   = cal_en && (evt_type == CAL_TYPE);
  assign any_en   = |mask;
  assign cur_ok   = mask[ptr];
  assign cur      = cur_ok ? ptr : next_en(ptr, mask);
  assign cnt_inc  = (cur_ok ? cnt : '0) + 1'b1;
  assign limit    = (grp == '0) ? GW'(1) : grp;
  assign grp_done = cnt_inc >= limit;
  assign pick     = is_cal ? cal_idx : (any_en ? cur : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_idx    <= '0;
      sel_onehot <= '0;
      ptr        <= '0;
      cnt        <= '0;
    end else begin
      sel_valid <= evt_stb;
      if (evt_stb) begin
        sel_idx    <= pick;
        sel_onehot <= NB'(1) << pick;
      end else begin
        sel_onehot <= '0;
      end
      if (evt_stb && !is_cal && any_en) begin
        if (grp_done) begin
          ptr <= next_en(cur, mask);
          cnt <= '0;
        end else begin
          ptr <= cur;
          cnt <= cnt_inc;
        end
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) evt_stb |=> sel_valid); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !evt_stb |=> !sel_valid); // R1
  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) sel_valid |-> sel_onehot == (NB'(1) << sel_idx)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !sel_valid |-> sel_onehot == '0); // R1
  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb && !is_cal && any_en) |=> ((($past(mask) >> sel_idx) & NB'(1)) != '0)); // R2
  AST_CAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (evt_stb && is_cal) |=> sel_idx == $past(cal_idx)); // R6
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (evt_stb && is_cal) |=> ($stable(ptr) && $stable(cnt))); // R8
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n) (evt_stb && !is_cal && !any_en) |=> sel_idx == '0); // R9
endmodule

// File: tb/evb_rr_select_tb.sv
`timescale 1ns/1ps
module evb_rr_select_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_stb = 1'b0;
  logic [3:0]  evt_type = 4'h0;
  logic [31:0] cfg_word = 32'h0000_0001;
  logic        sel_valid;
  logic [3:0]  sel_idx;
  logic [15:0] sel_onehot;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  evb_rr_select u_dut (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt_type(evt_type),
    .cfg_word(cfg_word), .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_onehot(sel_onehot)
  );

  // row = {pad3, cal_en, cal_idx, group, mask, trigger type, expected builder}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {3'b0,1'b0,4'd0,8'd1,16'h0025,4'h1,4'd0},
    {3'b0,1'b0,4'd0,8'd1,16'h0025,4'h1,4'd2},
    {3'b0,1'b0,4'd0,8'd1,16'h0025,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd1,16'h0025,4'h1,4'd0},
    {3'b0,1'b0,4'd0,8'd2,16'h0025,4'h1,4'd2},
    {3'b0,1'b0,4'd0,8'd2,16'h0025,4'h1,4'd2},
    {3'b0,1'b0,4'd0,8'd2,16'h0025,4'h1,4'd5},
    {3'b0,1'b1,4'd9,8'd2,16'h0025,4'hE,4'd9},
    {3'b0,1'b0,4'd0,8'd2,16'h0025,4'h1,4'd5},
    {3'b0,1'b0,4'd9,8'd2,16'h0025,4'hE,4'd0},
    {3'b0,1'b0,4'd0,8'd2,16'h0025,4'h1,4'd0},
    {3'b0,1'b0,4'd0,8'd0,16'h0025,4'h1,4'd2},
    {3'b0,1'b0,4'd0,8'd0,16'h0025,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd3,16'h0028,4'h1,4'd3},
    {3'b0,1'b0,4'd0,8'd3,16'h0028,4'h1,4'd3},
    {3'b0,1'b0,4'd0,8'd3,16'h0020,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd3,16'h0020,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd3,16'h0020,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd3,16'h0020,4'h1,4'd5},
    {3'b0,1'b0,4'd0,8'd1,16'h0000,4'h1,4'd0},
    {3'b0,1'b0,4'd0,8'd1,16'h8000,4'h1,4'd15},
    {3'b0,1'b0,4'd0,8'd1,16'h8001,4'h1,4'd15},
    {3'b0,1'b0,4'd0,8'd1,16'h8001,4'h1,4'd0},
    {3'b0,1'b1,4'd12,8'd1,16'h0000,4'hE,4'd12}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 3:       return "R3";
      4, 5, 6, 17, 18:  return "R4";
      7, 23:            return "R6";
      8:                return "R8";
      9, 10:            return "R7";
      11, 12:           return "R5";
      13, 14, 15, 16:   return "R10";
      19:               return "R9";
      default:          return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [31:0] cfg, input logic [3:0] t, input logic [3:0] exp, input string tag);
    @(negedge clk);
    cfg_word = cfg; evt_type = t; evt_stb = 1'b1;
    @(negedge clk);
    evt_stb = 1'b0;
    chk("R1", {31'b0, sel_valid}, 32'd1);
    chk(tag, {28'b0, sel_idx}, {28'b0, exp});
    chk("R1", {16'b0, sel_onehot}, 32'd1 << exp);
    @(negedge clk);
    chk("R1", {15'b0, sel_valid, sel_onehot}, 32'd0);
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] bexp [5];
    bexp = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd0};
    repeat (3) @(negedge clk);
    chk("R11", {15'b0, sel_valid, sel_onehot}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {27'b0, sel_valid, sel_idx}, 32'd0);

    for (int i = 0; i < NV; i++)
      ev(VEC[i][39:8], VEC[i][7:4], VEC[i][3:0], vec_tag(i));

    // R11: mid-run reset returns pointer to 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11", {11'b0, sel_valid, sel_idx, sel_onehot}, 32'd0);
    rst_n = 1'b1;
    ev({3'b0, 1'b0, 4'd0, 8'd1, 16'h0024}, 4'h3, 4'd2, "R11");

    // R3: back-to-back strobes, pointer at 5 disabled, wraps to 0
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i > 0) chk("R3", {27'b0, sel_valid, sel_idx}, {27'b0, 1'b1, bexp[i-1]});
      cfg_word = {3'b0, 1'b0, 4'd0, 8'd1, 16'h000F}; evt_type = 4'h2; evt_stb = 1'b1;
    end
    @(negedge clk);
    evt_stb = 1'b0;
    chk("R3", {27'b0, sel_valid, sel_idx}, {27'b0, 1'b1, bexp[4]});
    @(negedge clk);
    chk("R1", {31'b0, sel_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule